// File: doc/BRIEF.md
# Indirect Wide-Memory Access Port

This block gives a host, through a small set of 32-bit registers on a simple single-cycle register bus, access to two internal memories that are not mapped into its address space. The first is a control memory of 128-bit entries. The second is a byte-wide buffer memory. The host stages up to four data words and four bit-enable words in registers. It then writes a command register that carries the direction, the target memory and the entry address. Writing the command register starts the transfer.

The transfer finishes a fixed number of cycles later. At that point a sticky completion flag in the control register is set, and it stays set until software clears it. A control-memory read returns the whole entry in the four data registers. A control-memory write changes only the bits whose enable is set, so software can update one 16-bit half of one word and leave every other bit of the entry as it was. Both memories are modelled as register arrays that are cleared at reset.

Top module: `ctram_access_port`

## Requirements
- R1: After reset every register reads zero, and every entry of both memories reads back as zero.
- R2: A bus write to the command register (word index 1) starts a transfer. Command bit 31 set means write and clear means read. Command bit 30 set selects the byte memory and clear selects the control memory. Bits 29:0 give the entry address.
- R3: Control register bit 0 (word index 0) reads 1 from the second rising edge after the edge that accepted the command. Before that edge it reads 0.
- R4: The completion flag stays 1 until the host writes the control register with bit 0 equal to 0. A control write with bit 0 equal to 1 leaves the flag unchanged.
- R5: A control-memory write sets entry bit 32k+i to data word k bit i only where enable word k bit i is 1. All other bits of the entry keep their previous value.
- R6: Enable mask 0x0000FFFF or 0xFFFF0000 in one enable word, with the other three enable words zero, changes exactly that 16-bit half of the entry.
- R7: A control-memory read loads entry bits 32k+31:32k into data word k, for k = 0 to 3.
- R8: A byte-memory write stores bits 7:0 of data word 0. A byte-memory read sets data word 0 to the byte zero-extended and leaves data words 1 to 3 unchanged. Neither access alters the control memory.
- R9: A command write that arrives while a transfer is pending is ignored. The command register keeps the pending command, and the ignored command has no memory effect.
- R10: A write whose address is at or beyond the memory depth (144 control entries, 256 bytes) changes nothing. A read at such an address returns zeros.
- R11: Register word indices: 0 control, 1 command, 2 to 5 data words 0 to 3, 6 to 9 enable words 0 to 3. Data, enable and command registers read back the last value written. Unused indices read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Register writes take effect at the edge that samples the strobe. Register reads are combinational, so the bench samples them at the falling edge that follows. After a command is accepted, the completion flag and any read data are due after the second following rising edge. The bench samples the flag at the falling edges after the accepting edge and after the next edge, where it must be 0, and again after the second edge, where it must be 1. Data registers are compared only after that completion point, against a bench model of both memories updated with the masked-write rule.

// File: rtl/ctram_pkg.sv
package ctram_pkg;

    localparam int REG_W = 32;
    localparam int WORDS = 4;
    localparam int ENTRY_W = REG_W * WORDS;

    localparam logic [3:0] IDX_CTRL = 4'd0;
    localparam logic [3:0] IDX_CMD  = 4'd1;
    localparam logic [3:0] IDX_DAT0 = 4'd2;
    localparam logic [3:0] IDX_WEN0 = 4'd6;

    typedef struct packed {
        logic        wr;
        logic        to_byte;
        logic [29:0] addr;
    } cmd_t;

endpackage

// File: rtl/ctram_seq.sv
module ctram_seq #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = s_q.busy && (s_q.cnt == CW'(LAT - 1));
        if (fire) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("start lost"); // R2
    AST_ONE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire) else $error("double fire"); // R9
endmodule

// File: rtl/ctram_wide_mem.sv
module ctram_wide_mem #(
    parameter int DEPTH = 144,
    parameter int W     = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [29:0]   addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  wbits,
    output logic [W-1:0]  rdata
);
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];
    logic         in_range;
    logic [AW-1:0] idx;

    assign in_range = addr < 30'(DEPTH);
    assign idx      = addr[AW-1:0];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we && in_range)
            mem_d[idx] = (mem_q[idx] & ~wbits) | (wdata & wbits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = in_range ? mem_q[idx] : '0;

    AST_MASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we && in_range) |=> ((rdata & ~$past(wbits)) == ($past(rdata) & ~$past(wbits))) || ($past(addr) != addr))
        else $error("unmasked bits changed"); // R5
endmodule

// File: rtl/ctram_byte_mem.sv
module ctram_byte_mem #(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [29:0] addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata
);
    localparam int AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [7:0]    mem_d [DEPTH];
    logic [7:0]    mem_q [DEPTH];
    logic          in_range;
    logic [AW-1:0] idx;

    assign in_range = addr < 30'(DEPTH);
    assign idx      = addr[AW-1:0];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we && in_range) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = in_range ? mem_q[idx] : 8'h00;
endmodule

// File: rtl/ctram_access_port.sv
module ctram_access_port
    import ctram_pkg::*;
#(
    parameter int CT_DEPTH = 144,
    parameter int DB_DEPTH = 256,
    parameter int LAT      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    typedef struct packed {
        logic                        done;
        cmd_t                        cmd;
        logic [WORDS-1:0][REG_W-1:0] dat;
        logic [WORDS-1:0][REG_W-1:0] wen;
    } regs_t;

    regs_t s_d, s_q;

    logic               busy, fire, accept;
    logic               ct_we, db_we;
    logic [ENTRY_W-1:0] ct_rdata;
    logic [7:0]         db_rdata;

    assign accept = reg_wr && (reg_addr == IDX_CMD) && !busy;

    ctram_seq #(.LAT(LAT)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .busy  (busy),
        .fire  (fire)
    );

    assign ct_we = fire && s_q.cmd.wr && !s_q.cmd.to_byte;
    assign db_we = fire && s_q.cmd.wr &&  s_q.cmd.to_byte;

    ctram_wide_mem #(.DEPTH(CT_DEPTH), .W(ENTRY_W)) u_ct (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ct_we),
        .addr  (s_q.cmd.addr),
        .wdata (s_q.dat),
        .wbits (s_q.wen),
        .rdata (ct_rdata)
    );

    ctram_byte_mem #(.DEPTH(DB_DEPTH)) u_db (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (db_we),
        .addr  (s_q.cmd.addr),
        .wdata (s_q.dat[0][7:0]),
        .rdata (db_rdata)
    );

    always_comb begin
        s_d = s_q;
        if (reg_wr) begin
            if (reg_addr == IDX_CTRL) begin
                if (!reg_wdata[0]) s_d.done = 1'b0;
            end else if (reg_addr == IDX_CMD) begin
                if (accept) s_d.cmd = cmd_t'(reg_wdata);
            end
            for (int k = 0; k < WORDS; k++) begin
                if (reg_addr == IDX_DAT0 + 4'(k)) s_d.dat[k] = reg_wdata;
                if (reg_addr == IDX_WEN0 + 4'(k)) s_d.wen[k] = reg_wdata;
            end
        end
        if (fire) begin
            s_d.done = 1'b1;
            if (!s_q.cmd.wr) begin
                if (s_q.cmd.to_byte) begin
                    s_d.dat[0] = {24'h0, db_rdata};
                end else begin
                    for (int k = 0; k < WORDS; k++)
                        s_d.dat[k] = ct_rdata[k*REG_W +: REG_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == IDX_CTRL) reg_rdata = {31'h0, s_q.done};
        if (reg_addr == IDX_CMD)  reg_rdata = s_q.cmd;
        for (int k = 0; k < WORDS; k++) begin
            if (reg_addr == IDX_DAT0 + 4'(k)) reg_rdata = s_q.dat[k];
            if (reg_addr == IDX_WEN0 + 4'(k)) reg_rdata = s_q.wen[k];
        end
    end

    AST_DONE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> s_q.done) else $error("done missing"); // R3
    AST_DONE_ONLY_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(fire)) else $error("spurious done"); // R3
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !(reg_wr && reg_addr == IDX_CTRL && !reg_wdata[0])) |=> s_q.done)
        else $error("done dropped"); // R4
    AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.cmd)) else $error("pending command replaced"); // R9
endmodule

// File: tb/ctram_access_port_tb.sv
module ctram_access_port_tb;
    localparam int CTD = 144;
    localparam int DBD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [127:0] ct_m [CTD];
    logic [7:0]   db_m [DBD];
    logic [31:0]  dat_m [4];
    logic [31:0]  wen_m [4];

    always #4 clk = ~clk;

    ctram_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
        report();
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [127:0] merge(input logic [127:0] old);
        logic [127:0] dv = {dat_m[3], dat_m[2], dat_m[1], dat_m[0]};
        logic [127:0] ev = {wen_m[3], wen_m[2], wen_m[1], wen_m[0]};
        return (old & ~ev) | (dv & ev);
    endfunction

    // issue a command, check completion timing, apply model, clear done
    task automatic xfer(input bit w, input bit b, input int addr, input string req);
        logic [31:0] v;
        wr(4'd1, {w, b, 30'(addr)});
        #1 v = reg_rdata;
        reg_addr = 4'd0; #1 v = reg_rdata;
        chk(v == 0, "R3 early", v, 0);
        @(posedge clk); @(negedge clk); #1 v = reg_rdata;
        chk(v == 0, "R3 early", v, 0);
        @(posedge clk); @(negedge clk); #1 v = reg_rdata;
        chk(v == 1, "R3 done", v, 1);
        if (w && !b && addr < CTD) ct_m[addr] = merge(ct_m[addr]);
        if (w && b && addr < DBD) db_m[addr] = dat_m[0][7:0];
        if (!w && !b) for (int k = 0; k < 4; k++)
            dat_m[k] = (addr < CTD) ? ct_m[addr][k*32 +: 32] : 32'h0;
        if (!w && b) dat_m[0] = {24'h0, (addr < DBD) ? db_m[addr] : 8'h0};
        for (int k = 0; k < 4; k++) begin
            rd(4'(2 + k), v);
            chk(v == dat_m[k], req, v, dat_m[k]);
        end
        wr(4'd0, 32'h0);
    endtask

    task automatic set_dat(input int k, input logic [31:0] d);
        dat_m[k] = d; wr(4'(2 + k), d);
    endtask
    task automatic set_wen(input int k, input logic [31:0] d);
        wen_m[k] = d; wr(4'(6 + k), d);
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < CTD; i++) ct_m[i] = '0;
        for (int i = 0; i < DBD; i++) db_m[i] = '0;
        for (int k = 0; k < 4; k++) begin dat_m[k] = 0; wen_m[k] = 0; end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state of registers
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), v);
            chk(v == 0, "R1 reg reset", v, 0);
        end
        xfer(1'b0, 1'b0, 143, "R1 ct reset");
        xfer(1'b0, 1'b1, 5, "R1 byte reset");

        // R11 readback and unused index
        set_wen(2, 32'hA5A5_0F0F);
        rd(4'd8, v); chk(v == 32'hA5A5_0F0F, "R11 wen readback", v, 32'hA5A5_0F0F);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, v); chk(v == 0, "R11 unused", v, 0);

        // R5 full write, R7 read back
        for (int k = 0; k < 4; k++) begin set_dat(k, 32'h1111_1111 * (k + 1)); set_wen(k, 32'hFFFF_FFFF); end
        xfer(1'b1, 1'b0, 10, "R2 write");
        rd(4'd1, v); chk(v == {1'b1, 1'b0, 30'd10}, "R2 cmd readback", v, {1'b1, 1'b0, 30'd10});
        for (int k = 0; k < 4; k++) set_dat(k, 0);
        xfer(1'b0, 1'b0, 10, "R7 read");

        // R6 half-word updates
        for (int k = 0; k < 4; k++) set_wen(k, 0);
        set_wen(1, 32'hFFFF_0000);
        set_dat(1, 32'hDEAD_BEEF);
        xfer(1'b1, 1'b0, 10, "R6 upper half");
        xfer(1'b0, 1'b0, 10, "R6 upper half read");
        set_wen(1, 32'h0);
        set_wen(3, 32'h0000_FFFF);
        set_dat(3, 32'h1234_5678);
        xfer(1'b1, 1'b0, 10, "R6 lower half");
        xfer(1'b0, 1'b0, 10, "R6 lower half read");

        // R4 sticky done
        wr(4'd1, {2'b00, 30'd10});
        repeat (3) @(posedge clk);
        wr(4'd0, 32'h1);
        rd(4'd0, v); chk(v == 1, "R4 write 1 keeps", v, 1);
        repeat (5) @(posedge clk);
        rd(4'd0, v); chk(v == 1, "R4 held", v, 1);
        wr(4'd0, 32'hFFFF_FFFE);
        rd(4'd0, v); chk(v == 0, "R4 cleared", v, 0);

        // R9 command during pending transfer ignored
        for (int k = 0; k < 4; k++) begin set_dat(k, 32'hCAFE_0000 + k); set_wen(k, 32'hFFFF_FFFF); end
        @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = {2'b00, 30'd20};
        @(posedge clk); @(negedge clk); reg_wdata = {2'b10, 30'd21};
        @(posedge clk); @(negedge clk); reg_wr = 1'b0;
        rd(4'd1, v); chk(v == {2'b00, 30'd20}, "R9 cmd kept", v, {2'b00, 30'd20});
        for (int k = 0; k < 4; k++) dat_m[k] = 0;
        rd(4'd2, v); chk(v == 0, "R9 read result", v, 0);
        wr(4'd0, 0);
        for (int k = 0; k < 4; k++) set_dat(k, 0);
        xfer(1'b0, 1'b0, 21, "R9 no write");

        // R10 out of range
        for (int k = 0; k < 4; k++) set_dat(k, 32'h7777_7777);
        xfer(1'b1, 1'b0, 144, "R10 write oob");
        xfer(1'b0, 1'b0, 144, "R10 read oob");
        xfer(1'b0, 1'b0, 143, "R10 last entry untouched");

        // R8 byte memory
        set_dat(0, 32'hFFFF_FF3C);
        set_dat(2, 32'h0BAD_F00D);
        xfer(1'b1, 1'b1, 255, "R8 byte write");
        set_dat(0, 0);
        xfer(1'b0, 1'b1, 255, "R8 byte read");
        xfer(1'b0, 1'b0, 255 - 112, "R8 ct untouched");

        // random mix
        for (int n = 0; n < 120; n++) begin
            int sel = int'($urandom_range(0, 3));
            int ad = (sel[0]) ? int'($urandom_range(0, 260)) : int'($urandom_range(0, 150));
            for (int k = 0; k < 4; k++) begin
                set_dat(k, $urandom());
                set_wen(k, ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom());
            end
            xfer(sel[1], sel[0], ad, sel[0] ? "R8 random" : "R5 random");
        end

        report();
    end
endmodule